// File: doc/BRIEF.md
# Lockable Watchdog with Timed Reset Output

This block is a hardware watchdog for a small 8-bit controller core. It watches writes on the core's special-function-register bus. It stays idle until software writes a two-byte key to its control address. Once armed, it counts machine cycles. Software must repeat the same key before the count runs out, or the block raises a reset request.

Software can never stop the watchdog again. Only two things disarm it: the external reset input, or the block's own overflow. On overflow, the block drives a reset-out pulse of fixed length, counted in oscillator (clock) periods. The length depends on the clock-mode input.

The control register is write-only and the counter cannot be reached from the bus. The only visible effect of the block is its reset-out pin.

Top module: `wdog_guard`

## Requirements
- R1: After the external reset (`rst_n` low), the block is disarmed and `rst_out` is low. With no key written, `rst_out` never rises, however many machine cycles pass.
- R2: The block is armed by a write of 0x1E followed by a write of 0xE1, both to address 0xA6. The counter then starts from zero. `rst_out` rises in the clock cycle after the 16383rd counted machine-cycle edge that follows the edge capturing the 0xE1 write.
- R3: The counter advances only on clock edges where `mc_tick` is high. Edges with `mc_tick` low delay the overflow by exactly that many edges.
- R4: Writing the same 0x1E then 0xE1 pair while armed clears the counter to zero. The overflow then follows 16383 counted edges after the second write. If a tick arrives on the same edge as the clearing write, the clear wins.
- R5: A key sequence that is broken returns the sequence tracker to idle and has no effect on the counter or the armed state. This covers a lone 0xE1 and any byte other than 0xE1 after 0x1E. A 0x1E after 0x1E keeps the tracker waiting for 0xE1.
- R6: Writes to any address other than 0xA6 are ignored and leave the sequence tracker unchanged. For example, 0x1E to 0xA6, then any write elsewhere, then 0xE1 to 0xA6 still arms the block.
- R7: While armed, no write of any value disarms the block. Only writes completing the key pair affect the counter.
- R8: The overflow pulse on `rst_out` lasts 98 clock periods when `fast_mode` is 1 and 196 clock periods when `fast_mode` is 0. The mode is taken on the overflow edge.
- R9: During the pulse, the block is held disarmed with its counter at zero, and bus writes are ignored. After the pulse, the block stays disarmed until a new key pair is written.
- R10: Asserting `rst_n` while armed disarms the block, so no later overflow occurs without a new key pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| fast_mode | input | 1 | 1: 6-clock mode (98-clock pulse), 0: 12-clock mode (196-clock pulse) |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| rst_out | output | 1 | Reset request pulse, active high |

## Verification
The only observable result is the time and width of `rst_out` pulses. A wrong armed flag, tracker state or counter value shows up at the ports only as a pulse that is missing, extra or shifted in time. That difference can appear as much as 16383 machine cycles after the fault.

The checks therefore predict the exact clock cycle each pulse should start and how long it should last. They also watch long quiet windows to confirm that no pulse occurs. Internal faults are caught earlier by properties on the counter and the armed flag.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int          CNT_W     = 14,
  parameter logic [7:0]  CTRL_ADDR = 8'hA6,
  parameter logic [7:0]  KEY_A     = 8'h1E,
  parameter logic [7:0]  KEY_B     = 8'hE1,
  parameter int          FAST_W    = 98,
  parameter int          SLOW_W    = 196
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       fast_mode,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_we,
  output logic       rst_out
);

  localparam int             PW       = $clog2(SLOW_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}} - 1'b1;
  localparam logic [PW-1:0]  FAST_LD  = PW'(FAST_W);
  localparam logic [PW-1:0]  SLOW_LD  = PW'(SLOW_W);

  logic             armed;
  logic             key_seen;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pulse_left;

  wire in_pulse = pulse_left != '0;
  wire hit      = sfr_we && (sfr_addr == CTRL_ADDR) && !in_pulse;
  wire wr_a     = hit && (sfr_wdata == KEY_A);
  wire wr_b     = hit && (sfr_wdata == KEY_B) && key_seen;
  wire fire     = armed && mc_tick && !wr_b && (cnt == CNT_LAST);

  assign rst_out = in_pulse;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        key_seen <= 1'b0;
    else if (in_pulse) key_seen <= 1'b0;
    else if (hit)      key_seen <= wr_a;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     armed <= 1'b0;
    else if (fire)  armed <= 1'b0;
    else if (wr_b)  armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        cnt <= '0;
    else if (fire || wr_b || !armed)   cnt <= '0;
    else if (mc_tick)                  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pulse_left <= '0;
    else if (fire)     pulse_left <= fast_mode ? FAST_LD : SLOW_LD;
    else if (in_pulse) pulse_left <= pulse_left - 1'b1;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int          CNT_W     = 14,
  parameter logic [7:0]  CTRL_ADDR = 8'hA6,
  parameter logic [7:0]  KEY_B     = 8'hE1,
  parameter int          FAST_W    = 98,
  parameter int          SLOW_W    = 196
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_tick,
  input logic             fast_mode,
  input logic [7:0]       sfr_addr,
  input logic [7:0]       sfr_wdata,
  input logic             sfr_we,
  input logic             rst_out,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);

  logic [15:0] hi_len;
  logic        mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_len <= '0;
      mode_q <= 1'b0;
    end else begin
      hi_len <= rst_out ? hi_len + 16'd1 : 16'd0;
      if (!rst_out) mode_q <= fast_mode;
    end

  wire key_b_wr = sfr_we && (sfr_addr == CTRL_ADDR) && (sfr_wdata == KEY_B);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != {CNT_W{1'b1}});                                              // R2
  AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_b_wr));                                  // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mc_tick && !key_b_wr |=> $stable(cnt));                   // R3
  AST_NO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed || rst_out);                                        // R7
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> hi_len == (mode_q ? 16'(FAST_W) : 16'(SLOW_W))); // R8
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> !armed && cnt == '0);                                   // R9

endmodule

bind wdog_guard wdog_guard_chk #(
  .CNT_W(CNT_W), .CTRL_ADDR(CTRL_ADDR), .KEY_B(KEY_B),
  .FAST_W(FAST_W), .SLOW_W(SLOW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .fast_mode(fast_mode),
  .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
  .rst_out(rst_out), .armed(armed), .cnt(cnt)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
  localparam int LIMIT = (1 << 14) - 1;

  typedef struct {int start; int width; string tag;} pulse_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b1;
  logic       fast_mode = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_we = 1'b0;
  logic       rst_out;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  pulse_t exp_q[$];

  wdog_guard u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .fast_mode(fast_mode),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .rst_out(rst_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected pulses and compares start cycle and width
  bit prev = 1'b0, have = 1'b0;
  int rise = 0;
  pulse_t cur;
  always @(negedge clk) begin
    if (rst_out && !prev) begin
      rise = cyc;
      pulses++;
      if (exp_q.size() == 0) begin
        have = 1'b0;
        chk(1'b0, "unexpected pulse R1 R5 R9 R10", rise, -1);
      end else begin
        cur = exp_q.pop_front();
        have = 1'b1;
        chk(rise == cur.start, {cur.tag, " start"}, rise, cur.start);
      end
    end
    if (!rst_out && prev && have)
      chk(cyc - rise == cur.width, {cur.tag, " width R8"}, cyc - rise, cur.width);
    prev = rst_out;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog timeout", cyc, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, s;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rst_out == 1'b0, "R1 reset level", rst_out, 0);
    idle(16400);
    chk(pulses == 0, "R1 no pulse unarmed", pulses, 0);

    // R5 broken sequences
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1); wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);
    idle(16400);
    chk(pulses == 0, "R5 broken key no arm", pulses, 0);

    // R6 foreign writes between key bytes; R3 tick gap; R7 junk while armed
    wr(8'hA6, 8'h1E); wr(8'hA5, 8'hE1); wr(8'h70, 8'h33); wr(8'hA6, 8'hE1);
    n = cyc;
    chk(rst_out == 1'b0, "R2 no pulse at arm", rst_out, 0);
    exp_q.push_back('{n + LIMIT + 500, 98, "R2 R3 R6 R7"});
    idle(100);
    mc_tick = 1'b0; idle(500); mc_tick = 1'b1;
    wr(8'hA6, 8'h00); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h7F); wr(8'hA6, 8'hFF);
    while (cyc < n + LIMIT + 1) @(negedge clk);
    chk(rst_out == 1'b0, "R3 no pulse before gap delay", rst_out, 0);
    while (!rst_out) @(negedge clk);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    while (rst_out) @(negedge clk);
    idle(16400);
    chk(pulses == 1, "R9 disarmed after pulse", pulses, 1);

    // R4 service, slow mode
    fast_mode = 1'b0;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    idle(10000);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    s = cyc;
    exp_q.push_back('{s + LIMIT, 196, "R4"});
    while (pulses < 2) @(negedge clk);
    while (rst_out) @(negedge clk);
    idle(2);

    // R10 external reset disarms
    fast_mode = 1'b1;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    idle(200);
    rst_n = 1'b0; idle(3); rst_n = 1'b1;
    @(negedge clk);
    chk(rst_out == 1'b0, "R10 level after reset", rst_out, 0);
    idle(16400);
    chk(pulses == 2, "R10 no pulse after reset", pulses, 2);
    chk(exp_q.size() == 0, "R2 R4 all pulses seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule